// File: doc/BRIEF.md
# Global-history correlating branch direction predictor

This block predicts whether a conditional branch will be taken. It keeps a short global record of the most recent branch outcomes, whichever branches produced them. The low-order word-address bits of the branch PC pick a row of saturating 2-bit counters. The global record then picks one counter inside that row. The upper bit of that counter is the predicted direction. The same branch can therefore be predicted differently depending on what the preceding branches did.

The fetch stage drives a PC on the predict port and reads the direction back in the same cycle. The execute stage reports each resolved branch on the update port. On an update, only the counter that the branch's PC and the current global record select is trained, and the real outcome is then shifted into the record. No tags are stored, so branches whose index bits match share counters. With the default parameters the table holds 1024 counters: 256 rows by 4 history columns. If the history length is set to zero, the block becomes a plain table of 2-bit counters indexed by the PC.

Top module: `corr_dir_pred`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the global history is 00, so every PC predicts not taken.
- R2: `pred_taken` is combinational. It equals bit 1 of the counter in row `pred_pc[9:2]`, column equal to the current history value.
- R3: Counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A taken update increments the selected counter and a not-taken update decrements it. The counter saturates at 11 and at 00.
- R4: Each update shifts the history one place toward the MSB and puts the actual outcome (1 = taken) into bit 0. Without an update the history holds its value.
- R5: From a strong state, one opposite outcome does not change the predicted direction. Two consecutive opposite outcomes do.
- R6: An update changes only the counter in row `upd_pc[9:2]` and the current history column. Every other counter, including the other columns of the same row, keeps its value.
- R7: There is no tag check. PCs that agree in bits [9:2] and differ elsewhere read and train the same counters.
- R8: When a predict and an update occur in the same cycle, the prediction uses the counter and history values from before that update.
- R9: With the history length parameter at 0, the block behaves as a table of 2-bit counters selected only by `pc[9:2]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | PC of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
A prediction depends only on the current inputs and state, so it is due in the same cycle that `pred_pc` is applied. An update becomes visible only from the rising edge that samples `upd_valid`. The bench applies inputs at the falling edge and samples `pred_taken` one nanosecond later, before the committing edge. This checks both the same-cycle combinational result and the pre-update view required when predict and update coincide. A behavioural reference model advances its counters and history only after that edge and is compared on every cycle, for both the default configuration and a zero-history instance.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_SNT = 2'b00;
  localparam ctr2_t CTR_WNT = 2'b01;
  localparam ctr2_t CTR_WT  = 2'b10;
  localparam ctr2_t CTR_ST  = 2'b11;

  localparam ctr2_t CTR_RESET = CTR_WNT;

  // Saturating step of a 2-bit counter toward the resolved outcome.
  function automatic ctr2_t ctr_train(input ctr2_t cur, input logic taken);
    ctr2_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = cur + 2'd1;
    end else begin
      if (cur != CTR_SNT) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

  // Direction encoded by a counter: its upper bit.
  function automatic logic ctr_dir(input ctr2_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/cdp_hist_reg.sv
module cdp_hist_reg #(
  parameter int HIST_W = 2,
  localparam int HW_EFF = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              outcome,
  output logic [HW_EFF-1:0] hist_o,
  output logic [HW_EFF-1:0] hist_next_o
);

  generate
    if (HIST_W == 0) begin : g_none
      logic unused_hist_in;
      assign unused_hist_in = clk ^ rst_n ^ push ^ outcome;
      assign hist_o      = '0;
      assign hist_next_o = '0;
    end else begin : g_shift
      logic [HIST_W-1:0] hist_q;
      logic [HIST_W-1:0] shifted;
      if (HIST_W == 1) begin : g_one
        assign shifted = outcome;
      end else begin : g_many
        assign shifted = {hist_q[HIST_W-2:0], outcome};
      end
      assign hist_next_o = push ? shifted : hist_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_next_o;
      end
      assign hist_o = hist_q;
    end
  endgenerate

endmodule

// File: rtl/cdp_index.sv
module cdp_index #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int ROW_W  = 8,
  parameter int HIST_W = 2,
  localparam int HW_EFF = (HIST_W > 0) ? HIST_W : 1,
  localparam int IDX_W  = ROW_W + HIST_W,
  localparam int ROW_HI = PC_LSB + ROW_W - 1
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HW_EFF-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  logic [ROW_W-1:0] row;
  assign row = pc[ROW_HI:PC_LSB];

  // Bits outside the row field carry no tag and are deliberately ignored.
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[PC_W-1:ROW_HI+1], pc[PC_LSB-1:0]};

  generate
    if (HIST_W == 0) begin : g_row_only
      logic unused_hist_bits;
      assign unused_hist_bits = ^hist;
      assign idx = row;
    end else begin : g_row_hist
      assign idx = {row, hist};
    end
  endgenerate

endmodule

// File: rtl/cdp_ctr_table.sv
module cdp_ctr_table
  import cdp_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output ctr2_t            rd_a_ctr,
  input  logic [IDX_W-1:0] rd_b_idx,
  output ctr2_t            rd_b_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr2_t            wr_ctr
);

  ctr2_t cells [DEPTH];

  assign rd_a_ctr = cells[rd_a_idx];
  assign rd_b_ctr = cells[rd_b_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= CTR_RESET;
    end else if (wr_en) begin
      cells[wr_idx] <= wr_ctr;
    end
  end

endmodule

// File: rtl/corr_dir_pred.sv
module corr_dir_pred
  import cdp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int ROW_W  = 8,
  parameter int HIST_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam int HW_EFF = (HIST_W > 0) ? HIST_W : 1;
  localparam int IDX_W  = ROW_W + HIST_W;

  // Named internal events, brought out for the checker.
  logic [HW_EFF-1:0] hist_q;
  logic [HW_EFF-1:0] hist_next;
  logic [IDX_W-1:0]  pred_idx;
  logic [IDX_W-1:0]  upd_idx;
  ctr2_t             pred_ctr;
  ctr2_t             upd_ctr_old;
  ctr2_t             upd_ctr_new;

  cdp_hist_reg #(.HIST_W(HIST_W)) hist_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (upd_valid),
    .outcome     (upd_taken),
    .hist_o      (hist_q),
    .hist_next_o (hist_next)
  );

  cdp_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .ROW_W(ROW_W), .HIST_W(HIST_W)) pidx_i (
    .pc   (pred_pc),
    .hist (hist_q),
    .idx  (pred_idx)
  );

  cdp_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .ROW_W(ROW_W), .HIST_W(HIST_W)) uidx_i (
    .pc   (upd_pc),
    .hist (hist_q),
    .idx  (upd_idx)
  );

  cdp_ctr_table #(.IDX_W(IDX_W)) tbl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (pred_idx),
    .rd_a_ctr (pred_ctr),
    .rd_b_idx (upd_idx),
    .rd_b_ctr (upd_ctr_old),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_ctr   (upd_ctr_new)
  );

  assign upd_ctr_new = ctr_train(upd_ctr_old, upd_taken);
  assign pred_taken  = ctr_dir(pred_ctr);

  logic unused_hist_next;
  assign unused_hist_next = ^hist_next;

endmodule

// File: rtl/cdp_checker.sv
module cdp_checker
  import cdp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2,
  localparam int HW_EFF = (HIST_W > 0) ? HIST_W : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pred_pc,
  input logic              pred_taken,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HW_EFF-1:0] hist_q,
  input ctr2_t             upd_ctr_old,
  input ctr2_t             upd_ctr_new
);

  // R3: a taken outcome never lowers the trained counter
  p_up_on_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |-> (upd_ctr_new >= upd_ctr_old));

  // R3: a not-taken outcome never raises the trained counter
  p_down_on_not_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |-> (upd_ctr_new <= upd_ctr_old));

  // R3: the counter stays put only when already saturated in that direction
  p_saturate_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_ctr_new == upd_ctr_old)) |->
      ((upd_taken && upd_ctr_old == CTR_ST) || (!upd_taken && upd_ctr_old == CTR_SNT)));

  // R2: with no write in the previous cycle and an unchanged PC, the prediction holds
  p_pred_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(upd_valid) && $stable(pred_pc)) |-> $stable(pred_taken));

  generate
    if (HIST_W > 0) begin : g_hist_chk
      // R4: an update shifts the outcome into bit 0
      p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (hist_q == HW_EFF'({$past(hist_q), $past(upd_taken)})));

      // R4: no update, no history change
      p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist_q));
    end
  endgenerate

endmodule

bind corr_dir_pred cdp_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pred_pc     (pred_pc),
  .pred_taken  (pred_taken),
  .upd_valid   (upd_valid),
  .upd_taken   (upd_taken),
  .hist_q      (hist_q),
  .upd_ctr_old (upd_ctr_old),
  .upd_ctr_new (upd_ctr_new)
);

// File: tb/corr_dir_pred_tb.sv
`timescale 1ns/1ps
module corr_dir_pred_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pred_a;
  logic        pred_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  corr_dir_pred dut_i (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_a),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  corr_dir_pred #(.HIST_W(0)) dut_h0_i (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_b),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  // Behavioural reference: integer counters 0..3, integer history.
  int m2 [1024];
  int m0 [256];
  int h2;

  function automatic int row_of(input logic [31:0] pc);
    return (pc / 4) % 256;
  endfunction

  function automatic int ref_pred2(input logic [31:0] pc);
    return (m2[row_of(pc) * 4 + h2] >= 2) ? 1 : 0;
  endfunction

  function automatic int ref_pred0(input logic [31:0] pc);
    return (m0[row_of(pc)] >= 2) ? 1 : 0;
  endfunction

  task automatic ref_update(input logic [31:0] pc, input logic t);
    int i;
    i = row_of(pc) * 4 + h2;
    if (t) begin
      if (m2[i] < 3) m2[i] = m2[i] + 1;
      if (m0[row_of(pc)] < 3) m0[row_of(pc)] = m0[row_of(pc)] + 1;
    end else begin
      if (m2[i] > 0) m2[i] = m2[i] - 1;
      if (m0[row_of(pc)] > 0) m0[row_of(pc)] = m0[row_of(pc)] - 1;
    end
    h2 = (h2 * 2 + (t ? 1 : 0)) % 4;
  endtask

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, sample 1 ns later, commit at the rising edge.
  task automatic step(input logic [31:0] ppc, input logic uv, input logic [31:0] upc,
                      input logic ut, input string tag, input int exp_dir);
    pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    #1;
    check(int'(pred_a), ref_pred2(ppc), {tag, " model"});
    check(int'(pred_b), ref_pred0(ppc), "R9 model");
    if (exp_dir >= 0) check(int'(pred_a), exp_dir, {tag, " directed"});
    @(posedge clk);
    if (uv) ref_update(upc, ut);
    @(negedge clk);
  endtask

  task automatic upd(input logic [31:0] pc, input logic t, input string tag);
    step(32'h0, 1'b1, pc, t, tag, -1);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  localparam logic [31:0] P = 32'h0000_0200;
  localparam logic [31:0] Q = 32'h0000_0300;

  initial begin
    for (int i = 0; i < 1024; i++) m2[i] = 1;
    for (int i = 0; i < 256; i++) m0[i] = 1;
    h2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state predicts not taken everywhere
    step(32'h0000_0000, 0, 0, 0, "R1", 0);
    step(P, 0, 0, 0, "R1", 0);
    step(32'hFFFF_FFFC, 0, 0, 0, "R1", 0);

    // R3 / R4: train P four times taken; history walks 00 -> 01 -> 11 -> 11
    upd(P, 1, "R4");
    upd(P, 1, "R4");
    upd(P, 1, "R3");
    upd(P, 1, "R3");
    step(P, 0, 0, 0, "R3", 1);          // counter [P,11] = 11
    upd(P, 1, "R3");                    // saturation at 11
    upd(P, 0, "R5");                    // [P,11] 11 -> 10, history 10
    upd(Q, 1, "R4");                    // history 01
    upd(Q, 1, "R4");                    // history 11
    step(P, 0, 0, 0, "R5", 1);          // one miss: still taken
    upd(P, 0, "R5");                    // [P,11] 10 -> 01, history 10
    upd(Q, 1, "R4");
    upd(Q, 1, "R4");                    // history 11
    step(P, 0, 0, 0, "R5", 0);          // two misses: flipped
    upd(Q, 0, "R6");
    upd(Q, 0, "R6");                    // history 00
    step(P, 0, 0, 0, "R6", 1);          // column 00 of P untouched at 10
    step(P + 32'h0000_1001, 0, 0, 0, "R7", 1);  // alias via bits 12 and 0
    step(32'h0000_0000, 0, 0, 0, "R6", 0);      // other row untouched
    // R8: same-cycle predict and update of P, history 00
    step(P, 1, P, 0, "R8", 1);          // pre-update value seen
    step(P, 0, 0, 0, "R8", 0);          // [P,00] now 01
    // R7: alias trains the same counter
    upd(P + 32'h0000_4002, 1, "R7");    // [P,00] 01 -> 10, history 01
    upd(Q, 0, "R7");                    // history 10
    upd(Q, 0, "R7");                    // history 00
    step(P, 0, 0, 0, "R7", 1);

    // Random traffic over a few rows with aliasing bits
    for (int n = 0; n < 3000; n++) begin
      step($urandom & 32'h0000_301F, 1'($urandom_range(0, 1)), $urandom & 32'h0000_301F,
           1'($urandom_range(0, 1)), (n % 2 == 0) ? "R4" : "R6", -1);
    end

    // Saturation at 00: many not-taken updates then check
    for (int n = 0; n < 8; n++) upd(P, 0, "R3");
    step(P, 0, 0, 0, "R3", 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule